// File: doc/BRIEF.md
# XON/XOFF and RTS Flow Controller

This block manages link flow control for a UART channel. It watches the character stream coming out of the receiver, compares each character against four programmable flow characters (two resume characters and two halt characters) and, when one matches under the selected receive mode, pauses or releases the local transmitter. Matched flow characters are consumed and never reach the receive FIFO. Every other character passes straight through to the FIFO write port in the same cycle.

In the other direction it watches the receive FIFO occupancy. When the occupancy climbs to the programmed halt level it drops RTS and asks the transmitter to send a halt character, or two of them. When the occupancy drains to the resume level it raises RTS again and asks for the resume character or characters. Levels are programmed as 4-bit codes counted in units of 8 FIFO entries. An optional CTS input, passed through a synchronizer, can also hold the transmitter. Sticky status flags record which flow characters were seen, and a strobe clears them.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: With sw_flow_en high, a valid received character is matched against xon_chr1/xoff_chr1 when flow_mode[1] is 1 and against xon_chr2/xoff_chr2 when flow_mode[0] is 1. A matched character holds fifo_wr_en low. An unmatched character drives fifo_wr_en high in the same cycle, with fifo_wr_data equal to rx_char.
- R2: A matched halt character raises tx_pause one cycle after the match when tx_busy is low. If tx_busy is high, tx_pause rises one cycle after the first cycle in which tx_busy is seen low. When a character equals both an active halt and an active resume character, the halt character takes precedence.
- R3: A matched resume character clears tx_pause one cycle later, together with any pause still waiting on tx_busy.
- R4: spc_status bit 0 records xon_chr1, bit 1 xon_chr2, bit 2 xoff_chr1 and bit 3 xoff_chr2. A bit is set one cycle after its match and stays set until a cycle with status_clr high. A match in the same cycle as status_clr leaves its bit set.
- R5: With a nonzero halt code (flow_levels[3:0]) and no halt in force, an occupancy of at least 8 times that code puts the block in the halted state in the next cycle. In that state rts is low when auto_rts_en is high, and one halt request sequence starts. A halt code of 0 disables halting.
- R6: While halted, an occupancy of at most 8 times the resume code (flow_levels[7:4]) leaves the halted state in the next cycle. rts goes high and one resume request sequence starts.
- R7: flow_mode[3:2] selects the requested characters. 01 requests the second character of the pair, 10 the first, 11 the first and then the second, and 00 none. send_req stays high with send_char valid until a cycle with send_ready high accepts the character. A new crossing replaces whatever is still pending.
- R8: A request sequence starts once per crossing. Occupancy that stays beyond the threshold does not repeat it.
- R9: With auto_rts_en low, rts is held high.
- R10: cts_in passes through SYNC_STAGES flip-flops that reset to the inactive level. With auto_cts_en high, tx_pause is high whenever the synchronized CTS is low.
- R11: With sw_flow_en low, no character is matched. Pending requests and the character-driven pause are cleared one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_flow_en | input | 1 | Enable for character-based flow control |
| auto_rts_en | input | 1 | Enable for automatic RTS from FIFO levels |
| auto_cts_en | input | 1 | Enable for CTS gating of the transmitter |
| flow_mode | input | 4 | [1:0] receive match mode, [3:2] transmit request mode |
| flow_levels | input | 8 | [3:0] halt code, [7:4] resume code, units of 8 entries |
| xon_chr1 | input | DATA_W | First resume character |
| xon_chr2 | input | DATA_W | Second resume character |
| xoff_chr1 | input | DATA_W | First halt character |
| xoff_chr2 | input | DATA_W | Second halt character |
| rx_valid | input | 1 | Received character valid |
| rx_char | input | DATA_W | Received character |
| fifo_wr_en | output | 1 | Receive FIFO write strobe |
| fifo_wr_data | output | DATA_W | Receive FIFO write data |
| fifo_level | input | LVL_W | Receive FIFO occupancy |
| tx_busy | input | 1 | Transmitter is mid-character |
| tx_pause | output | 1 | Hold the transmitter |
| send_req | output | 1 | Request to transmit a flow character |
| send_char | output | DATA_W | Flow character to transmit |
| send_ready | input | 1 | Transmitter accepts send_char this cycle |
| cts_in | input | 1 | Clear-to-send input, high means clear |
| rts | output | 1 | Ready-to-send output, high means ready |
| spc_status | output | 4 | Sticky flow-character flags |
| status_clr | input | 1 | Clear strobe for spc_status |

## Verification
The hardest cases to reach from the ports are the ones where two events meet. One is a halt character that arrives while the transmitter is mid-character, where the pause has to wait out tx_busy before it appears. The other is the two-character request sequence of mode 11, which only advances on accepted handshakes. Directed sequences hold tx_busy high across the match and release it later. They also step the FIFO occupancy one entry below, at and beyond each threshold while the bench controls send_ready cycle by cycle. A seeded random phase then mixes flow characters with ordinary ones under changing match modes and occasional clear strobes, so matches coincide with clears and halt/resume pairs fall in back-to-back cycles.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

    localparam int NUM_SPC = 4;

    // Index of each flow character in the packed character vector
    localparam int IDX_ON1  = 0;
    localparam int IDX_ON2  = 1;
    localparam int IDX_OFF1 = 2;
    localparam int IDX_OFF2 = 3;

    typedef enum logic {
        KIND_RESUME = 1'b0,
        KIND_HALT   = 1'b1
    } flow_kind_e;

    // Character set 1 (index 0 and 2) follows mode bit 1, set 2 follows bit 0
    function automatic logic set_active(input logic [1:0] mode, input int idx);
        return ((idx % 2) == 0) ? mode[1] : mode[0];
    endfunction

endpackage

// File: rtl/xfc_sync.sv
module xfc_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/xfc_char_match.sv
module xfc_char_match
    import xfc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                             rx_valid,
    input  logic [DATA_W-1:0]                rx_char,
    input  logic                             match_en,
    input  logic [1:0]                       rx_mode,
    input  logic [NUM_SPC-1:0][DATA_W-1:0]   spc_chars,
    output logic [NUM_SPC-1:0]               hit_vec,
    output logic                             xon_hit,
    output logic                             xoff_hit,
    output logic                             swallow
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SPC; gi++) begin : g_cmp
            always_comb begin
                hit_vec[gi] = rx_valid && match_en && set_active(rx_mode, gi)
                              && (rx_char == spc_chars[gi]);
            end
        end
    endgenerate

    always_comb begin
        xoff_hit = hit_vec[IDX_OFF1] | hit_vec[IDX_OFF2];
        xon_hit  = (hit_vec[IDX_ON1] | hit_vec[IDX_ON2]) & ~xoff_hit;
        swallow  = |hit_vec;
    end

endmodule

// File: rtl/xfc_level_mon.sv
module xfc_level_mon #(
    parameter int DEPTH  = 128,
    parameter int UNIT   = 8,
    parameter int CODE_W = 4,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [CODE_W-1:0] halt_code,
    input  logic [CODE_W-1:0] resume_code,
    output logic              halted,
    output logic              halt_evt,
    output logic              resume_evt
);

    localparam int TH_W = LVL_W + CODE_W + 4;

    typedef struct packed {
        logic halted;
    } lm_state_t;

    lm_state_t st_d, st_q;
    logic [TH_W-1:0] halt_th, resume_th, level_ext;

    always_comb begin
        halt_th    = TH_W'(halt_code) * TH_W'(UNIT);
        resume_th  = TH_W'(resume_code) * TH_W'(UNIT);
        level_ext  = TH_W'(fifo_level);
        halt_evt   = !st_q.halted && (halt_code != '0) && (level_ext >= halt_th);
        resume_evt = st_q.halted && (level_ext <= resume_th);
        st_d = st_q;
        if (halt_evt)        st_d.halted = 1'b1;
        else if (resume_evt) st_d.halted = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign halted = st_q.halted;

endmodule

// File: rtl/xfc_send_seq.sv
module xfc_send_seq
    import xfc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           gen_en,
    input  logic [1:0]                     gen_mode,
    input  logic                           halt_evt,
    input  logic                           resume_evt,
    input  logic [NUM_SPC-1:0][DATA_W-1:0] spc_chars,
    input  logic                           send_ready,
    output logic                           send_req,
    output logic [DATA_W-1:0]              send_char
);

    typedef struct packed {
        logic [1:0] pend;   // bit 0: set-1 character, bit 1: set-2 character
        flow_kind_e kind;
    } sq_state_t;

    sq_state_t st_d, st_q;

    always_comb begin
        send_req = |st_q.pend;
        if (st_q.kind == KIND_HALT)
            send_char = st_q.pend[0] ? spc_chars[IDX_OFF1] : spc_chars[IDX_OFF2];
        else
            send_char = st_q.pend[0] ? spc_chars[IDX_ON1] : spc_chars[IDX_ON2];

        st_d = st_q;
        if (!gen_en) begin
            st_d.pend = 2'b00;
        end else if (halt_evt || resume_evt) begin
            st_d.kind = halt_evt ? KIND_HALT : KIND_RESUME;
            st_d.pend = {gen_mode[0], gen_mode[1]};
        end else if (send_req && send_ready) begin
            if (st_q.pend[0]) st_d.pend[0] = 1'b0;
            else              st_d.pend[1] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pend: 2'b00, kind: KIND_RESUME};
        else        st_q <= st_d;
    end

endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl
    import xfc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int FIFO_DEPTH  = 128,
    parameter int LVL_UNIT    = 8,
    parameter int CODE_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_flow_en,
    input  logic                auto_rts_en,
    input  logic                auto_cts_en,
    input  logic [3:0]          flow_mode,
    input  logic [2*CODE_W-1:0] flow_levels,
    input  logic [DATA_W-1:0]   xon_chr1,
    input  logic [DATA_W-1:0]   xon_chr2,
    input  logic [DATA_W-1:0]   xoff_chr1,
    input  logic [DATA_W-1:0]   xoff_chr2,
    input  logic                rx_valid,
    input  logic [DATA_W-1:0]   rx_char,
    output logic                fifo_wr_en,
    output logic [DATA_W-1:0]   fifo_wr_data,
    input  logic [LVL_W-1:0]    fifo_level,
    input  logic                tx_busy,
    output logic                tx_pause,
    output logic                send_req,
    output logic [DATA_W-1:0]   send_char,
    input  logic                send_ready,
    input  logic                cts_in,
    output logic                rts,
    output logic [NUM_SPC-1:0]  spc_status,
    input  logic                status_clr
);

    typedef struct packed {
        logic               sw_pause;
        logic               pause_pend;
        logic [NUM_SPC-1:0] status;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NUM_SPC-1:0][DATA_W-1:0] spc_chars;
    logic [NUM_SPC-1:0]             hit_vec;
    logic xon_hit, xoff_hit, swallow;
    logic halted, halt_evt, resume_evt;
    logic cts_sync;

    assign spc_chars = {xoff_chr2, xoff_chr1, xon_chr2, xon_chr1};

    xfc_char_match #(.DATA_W(DATA_W)) u_match (
        .rx_valid  (rx_valid),
        .rx_char   (rx_char),
        .match_en  (sw_flow_en),
        .rx_mode   (flow_mode[1:0]),
        .spc_chars (spc_chars),
        .hit_vec   (hit_vec),
        .xon_hit   (xon_hit),
        .xoff_hit  (xoff_hit),
        .swallow   (swallow)
    );

    xfc_level_mon #(
        .DEPTH  (FIFO_DEPTH),
        .UNIT   (LVL_UNIT),
        .CODE_W (CODE_W),
        .LVL_W  (LVL_W)
    ) u_level (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_level  (fifo_level),
        .halt_code   (flow_levels[CODE_W-1:0]),
        .resume_code (flow_levels[2*CODE_W-1:CODE_W]),
        .halted      (halted),
        .halt_evt    (halt_evt),
        .resume_evt  (resume_evt)
    );

    xfc_send_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .gen_en     (sw_flow_en),
        .gen_mode   (flow_mode[3:2]),
        .halt_evt   (halt_evt),
        .resume_evt (resume_evt),
        .spc_chars  (spc_chars),
        .send_ready (send_ready),
        .send_req   (send_req),
        .send_char  (send_char)
    );

    xfc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_cts_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cts_in),
        .dout  (cts_sync)
    );

    always_comb begin
        st_d = st_q;
        if (!sw_flow_en || xon_hit) begin
            st_d.sw_pause   = 1'b0;
            st_d.pause_pend = 1'b0;
        end else if ((st_q.pause_pend || xoff_hit) && !tx_busy) begin
            st_d.sw_pause   = 1'b1;
            st_d.pause_pend = 1'b0;
        end else begin
            st_d.pause_pend = st_q.pause_pend | xoff_hit;
        end
        st_d.status = (status_clr ? '0 : st_q.status) | hit_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fifo_wr_en   = rx_valid & ~swallow;
    assign fifo_wr_data = rx_char;
    assign tx_pause     = st_q.sw_pause | (auto_cts_en & ~cts_sync);
    assign rts          = ~(auto_rts_en & halted);
    assign spc_status   = st_q.status;

endmodule

// File: rtl/xfc_checker.sv
module xfc_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_flow_en,
    input logic              auto_rts_en,
    input logic [3:0]        flow_mode,
    input logic [DATA_W-1:0] xon_chr1,
    input logic [DATA_W-1:0] xon_chr2,
    input logic [DATA_W-1:0] xoff_chr1,
    input logic [DATA_W-1:0] xoff_chr2,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_char,
    input logic              fifo_wr_en,
    input logic              tx_busy,
    input logic              tx_pause,
    input logic              send_req,
    input logic [DATA_W-1:0] send_char,
    input logic              rts,
    input logic [3:0]        spc_status,
    input logic              status_clr
);

    // R1
    swallow_xoff1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && sw_flow_en && flow_mode[1] && rx_char == xoff_chr1) |-> !fifo_wr_en);

    // R2
    pause_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && sw_flow_en && flow_mode[1] && rx_char == xoff_chr1 && !tx_busy) |=> tx_pause);

    // R4
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_clr |=> ((spc_status & $past(spc_status)) == $past(spc_status)));

    // R7
    send_char_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_req |-> (send_char == xon_chr1 || send_char == xon_chr2 ||
                      send_char == xoff_chr1 || send_char == xoff_chr2));

    // R9
    rts_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_rts_en |-> rts);

    // R11
    gen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_flow_en |=> !send_req);

endmodule

bind xonxoff_flow_ctrl xfc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_flow_en  (sw_flow_en),
    .auto_rts_en (auto_rts_en),
    .flow_mode   (flow_mode),
    .xon_chr1    (xon_chr1),
    .xon_chr2    (xon_chr2),
    .xoff_chr1   (xoff_chr1),
    .xoff_chr2   (xoff_chr2),
    .rx_valid    (rx_valid),
    .rx_char     (rx_char),
    .fifo_wr_en  (fifo_wr_en),
    .tx_busy     (tx_busy),
    .tx_pause    (tx_pause),
    .send_req    (send_req),
    .send_char   (send_char),
    .rts         (rts),
    .spc_status  (spc_status),
    .status_clr  (status_clr)
);

// File: tb/xonxoff_flow_ctrl_tb.sv
`timescale 1ns/1ps
module xonxoff_flow_ctrl_tb;

    localparam logic [7:0] ON1  = 8'h11;
    localparam logic [7:0] ON2  = 8'h12;
    localparam logic [7:0] OFF1 = 8'h13;
    localparam logic [7:0] OFF2 = 8'h14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_flow_en = 0, auto_rts_en = 0, auto_cts_en = 0;
    logic [3:0] flow_mode = 0;
    logic [7:0] flow_levels = 0;
    logic       rx_valid = 0;
    logic [7:0] rx_char = 0;
    logic       fifo_wr_en;
    logic [7:0] fifo_wr_data;
    logic [7:0] fifo_level = 0;
    logic       tx_busy = 0, tx_pause;
    logic       send_req, send_ready = 0;
    logic [7:0] send_char;
    logic       cts_in = 1, rts;
    logic [3:0] spc_status;
    logic       status_clr = 0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    xonxoff_flow_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sw_flow_en(sw_flow_en), .auto_rts_en(auto_rts_en),
        .auto_cts_en(auto_cts_en), .flow_mode(flow_mode), .flow_levels(flow_levels),
        .xon_chr1(ON1), .xon_chr2(ON2), .xoff_chr1(OFF1), .xoff_chr2(OFF2),
        .rx_valid(rx_valid), .rx_char(rx_char), .fifo_wr_en(fifo_wr_en),
        .fifo_wr_data(fifo_wr_data), .fifo_level(fifo_level), .tx_busy(tx_busy),
        .tx_pause(tx_pause), .send_req(send_req), .send_char(send_char),
        .send_ready(send_ready), .cts_in(cts_in), .rts(rts), .spc_status(spc_status),
        .status_clr(status_clr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_hits(input logic [1:0] mode, input logic v,
                                            input logic [7:0] c);
        logic [3:0] h;
        h[0] = v && mode[1] && c == ON1;
        h[1] = v && mode[0] && c == ON2;
        h[2] = v && mode[1] && c == OFF1;
        h[3] = v && mode[0] && c == OFF2;
        return h;
    endfunction

    task automatic nclk();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [3:0] e_stat;
        logic       e_pause;
        void'($urandom(32'd2024));
        repeat (3) nclk();
        rst_n = 1'b1;
        nclk();
        // reset state
        chk("R9 reset rts", rts, 1);
        chk("R7 reset send_req", send_req, 0);
        chk("R4 reset status", spc_status, 0);
        chk("R10 reset pause", tx_pause, 0);

        // R1/R2: halt char set 1, mode 10, transmitter idle
        sw_flow_en = 1; flow_mode = 4'b0010;
        rx_valid = 1; rx_char = OFF1;
        #1 chk("R1 xoff1 swallowed", fifo_wr_en, 0);
        nclk();
        rx_valid = 0;
        chk("R2 pause after xoff1", tx_pause, 1);
        chk("R4 status xoff1", spc_status, 4'b0100);

        // R1: mode 01 lets set-1 chars through and matches set 2
        flow_mode = 4'b0001; rx_valid = 1; rx_char = OFF1;
        #1 chk("R1 pass-through wr_en", fifo_wr_en, 1);
        chk("R1 pass-through data", fifo_wr_data, OFF1);
        nclk();
        chk("R1 unmatched no effect on pause", tx_pause, 1);
        rx_char = ON2;
        #1 chk("R1 xon2 swallowed", fifo_wr_en, 0);
        nclk();
        rx_valid = 0;
        chk("R3 pause cleared by xon2", tx_pause, 0);
        chk("R4 status accumulates", spc_status, 4'b0110);
        status_clr = 1;
        nclk();
        status_clr = 0;
        chk("R4 status cleared", spc_status, 0);

        // R4: match in the same cycle as clear keeps its bit
        flow_mode = 4'b0011; status_clr = 1; rx_valid = 1; rx_char = OFF2;
        nclk();
        status_clr = 0; rx_char = ON1;
        chk("R4 set wins over clear", spc_status, 4'b1000);
        chk("R2 pause after xoff2", tx_pause, 1);
        nclk();
        rx_valid = 0;
        chk("R3 pause cleared by xon1", tx_pause, 0);

        // R2: pause deferred while transmitter busy
        tx_busy = 1; flow_mode = 4'b0010; rx_valid = 1; rx_char = OFF1;
        nclk();
        rx_valid = 0;
        chk("R2 held while busy", tx_pause, 0);
        nclk();
        chk("R2 still held while busy", tx_pause, 0);
        tx_busy = 0;
        nclk();
        chk("R2 pause after busy drops", tx_pause, 1);
        rx_valid = 1; rx_char = ON1;
        nclk();
        rx_valid = 0;
        chk("R3 xon1 clears", tx_pause, 0);

        // R10: CTS gating through the synchronizer
        auto_cts_en = 1;
        nclk();
        chk("R10 cts clear no pause", tx_pause, 0);
        cts_in = 0;
        nclk();
        chk("R10 first sync stage", tx_pause, 0);
        nclk();
        chk("R10 pause on cts low", tx_pause, 1);
        cts_in = 1;
        nclk(); nclk();
        chk("R10 release on cts high", tx_pause, 0);
        auto_cts_en = 0;

        // R5-R8: levels, halt code 4 (32 entries), resume code 2 (16 entries)
        status_clr = 1; nclk(); status_clr = 0;
        auto_rts_en = 1; flow_levels = 8'h24; flow_mode = 4'b1100;
        fifo_level = 31;
        nclk();
        chk("R5 below halt rts", rts, 1);
        chk("R5 below halt no req", send_req, 0);
        fifo_level = 32;
        nclk();
        chk("R5 rts low at halt", rts, 0);
        chk("R5 halt request", send_req, 1);
        chk("R7 mode11 first xoff1", send_char, OFF1);
        send_ready = 1;
        nclk();
        chk("R7 mode11 second req", send_req, 1);
        chk("R7 mode11 second xoff2", send_char, OFF2);
        nclk();
        chk("R7 sequence done", send_req, 0);
        send_ready = 0; fifo_level = 40;
        for (int k = 0; k < 4; k++) begin
            nclk();
            chk("R8 no repeat while high", send_req, 0);
            chk("R8 rts stays low", rts, 0);
        end
        fifo_level = 17;
        nclk();
        chk("R6 above resume still halted", rts, 0);
        fifo_level = 16;
        nclk();
        chk("R6 rts high at resume", rts, 1);
        chk("R6 resume request", send_req, 1);
        chk("R7 mode11 first xon1", send_char, ON1);
        send_ready = 1;
        nclk();
        chk("R7 mode11 second xon2", send_char, ON2);
        nclk();
        chk("R7 resume sequence done", send_req, 0);
        send_ready = 0;

        // R7: mode 01 requests set-2 only, mode 10 set-1 only
        flow_mode = 4'b0100; fifo_level = 32;
        nclk();
        chk("R7 mode01 xoff2", send_char, OFF2);
        send_ready = 1;
        nclk();
        chk("R7 mode01 single char", send_req, 0);
        send_ready = 0; flow_mode = 4'b1000; fifo_level = 0;
        nclk();
        chk("R7 mode10 xon1", send_char, ON1);
        chk("R7 mode10 req", send_req, 1);
        send_ready = 1;
        nclk();
        chk("R7 mode10 single char", send_req, 0);
        send_ready = 0;

        // R9 and R11
        auto_rts_en = 0; fifo_level = 40;
        nclk();
        chk("R9 rts held high when auto off", rts, 1);
        chk("R5 halt request with rts off", send_req, 1);
        sw_flow_en = 0; rx_valid = 1; rx_char = OFF1; flow_mode = 4'b1011;
        #1 chk("R11 no match when disabled", fifo_wr_en, 1);
        nclk();
        rx_valid = 0;
        chk("R11 request dropped", send_req, 0);
        chk("R11 no pause", tx_pause, 0);
        chk("R11 no status", spc_status, 0);
        fifo_level = 0;
        nclk();

        // Random phase for R1-R4
        sw_flow_en = 1; flow_levels = 8'h00;
        e_stat = 0; e_pause = 0;
        for (int i = 0; i < 2000; i++) begin
            logic [3:0] h;
            nclk();
            chk("R4 random status", spc_status, e_stat);
            chk("R2/R3 random pause", tx_pause, e_pause);
            flow_mode  = {2'b00, 2'($urandom % 4)};
            rx_valid   = ($urandom % 4) != 0;
            rx_char    = 8'h10 + 8'($urandom % 6);
            status_clr = ($urandom % 8) == 0;
            h = exp_hits(flow_mode[1:0], rx_valid, rx_char);
            #1 chk("R1 random wr_en", fifo_wr_en, rx_valid && (h == 0));
            e_stat = (status_clr ? 4'b0 : e_stat) | h;
            if (h[2] | h[3])      e_pause = 1;
            else if (h[0] | h[1]) e_pause = 0;
        end
        nclk();
        chk("R4 final status", spc_status, e_stat);
        chk("R2 final pause", tx_pause, e_pause);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule